// File: doc/BRIEF.md
# Composite Ancillary Packet Flag Monitor

This block watches a 10-bit digital composite video sample stream together with the horizontal sample count that accompanies each word. It recognises the single-word marker that opens an ancillary data packet, checks that each marker falls inside a permitted word window, and reports a one-clock strobe for every legal packet start. A marker found outside every permitted window raises a window-error strobe instead.

The line standard (525-line, 910 samples per line, or 625-line, 1135 samples per line) and the kind of blanking interval the current line belongs to (horizontal sync, equalizing pulses, vertical sync, or none) come in as configuration inputs. Some vertical-sync windows run past the last sample of the line and continue from count 0. After a legal marker, the words that follow are treated as packet payload until the next marker arrives or the window closes. A payload word that takes one of the codes kept for timing raises a reserved-code error strobe.

All three strobes are registered. Each appears exactly one clock after the sample that caused it.

Top module: `anc_flag_watch`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, all three strobes are low and no packet is open.
- R2: A word equal to 0x3FC whose count lies inside a permitted window makes `pkt_start_o` high for exactly the following clock.
- R3: The window set is selected by `std_pal` (0 = 525-line, 1 = 625-line) and `ivl_sel` (0 = horizontal sync, 1 = equalizing, 2 = vertical sync, 3 = no window). For 525-line the windows are: horizontal 795..849; equalizing 795..815 and 340..360; vertical 795..260 and 340..715. For 625-line they are: horizontal 972..1035; equalizing 972..994 and 404..426; vertical 972..302 and 404..869.
- R4: A window whose first count exceeds its last count covers the first count up to line length minus one, and also 0 up to the last count. The line length is 910 (525-line) or 1135 (625-line). A count at or beyond the line length is outside every window.
- R5: A 0x3FC word outside every permitted window makes `win_err_o` high for the following clock, produces no `pkt_start_o`, and closes any open packet.
- R6: Inside an open packet, a non-marker word with a count inside a window whose value is 0x000..0x003 or 0x3FD..0x3FF makes `rsv_err_o` high for the following clock.
- R7: Markers on consecutive samples inside a window each produce their own `pkt_start_o` pulse, and each one opens a new packet.
- R8: Words seen before any legal marker, or after the count has left the window, never raise `rsv_err_o`. Leaving the window closes the packet, so in-window words that follow need a fresh marker before they are checked.
- R9: `pkt_start_o` and `win_err_o` are never high in the same cycle, and no output depends on the current input combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_pal | input | 1 | Line standard: 0 = 525-line, 1 = 625-line |
| ivl_sel | input | 2 | Interval kind: 0 horizontal sync, 1 equalizing, 2 vertical sync, 3 none |
| word_i | input | 10 | Video sample word |
| hcount_i | input | 11 | Horizontal sample count of `word_i` |
| pkt_start_o | output | 1 | Legal packet-start strobe |
| win_err_o | output | 1 | Marker-outside-window strobe |
| rsv_err_o | output | 1 | Reserved code in payload strobe |

## Verification
The hardest case to reach is a packet that stays open while the count wraps from the end of the line back to 0 inside a vertical-sync window, with reserved payload codes arriving on both sides of the wrap and the packet closing at the far edge. The stimulus sweeps complete lines under every standard and interval setting. Markers are placed on each window edge and just beyond it, and reserved codes are spread through the line, so payload runs cross the wrap point and the window boundaries. Directed steps add counts beyond the line length and back-to-back markers.

// File: rtl/anc_pkg.sv
package anc_pkg;

    localparam int WORD_W     = 10;
    localparam int HCOUNT_W   = 11;
    localparam int LINE_525   = 910;
    localparam int LINE_625   = 1135;
    localparam int NUM_SLOTS  = 2;

    localparam logic [WORD_W-1:0] MARKER_WORD = 10'h3FC;
    localparam logic [WORD_W-1:0] LOW_RSV_MAX = 10'h003;

    typedef enum logic [1:0] {
        IVL_HSYNC = 2'd0,
        IVL_EQ    = 2'd1,
        IVL_VSYNC = 2'd2,
        IVL_NONE  = 2'd3
    } ivl_e;

    typedef struct packed {
        logic                en;
        logic [HCOUNT_W-1:0] lo;
        logic [HCOUNT_W-1:0] hi;
    } span_t;

    typedef struct packed {
        logic in_pkt;
        logic start;
        logic win_err;
        logic rsv_err;
    } mon_state_t;

    function automatic span_t mk_span(input int lo, input int hi);
        span_t s;
        s.en = 1'b1;
        s.lo = HCOUNT_W'(lo);
        s.hi = HCOUNT_W'(hi);
        return s;
    endfunction

    function automatic span_t span_lookup(input logic pal, input ivl_e ivl, input int slot);
        span_t s;
        s = '0;
        unique case (ivl)
            IVL_HSYNC: if (slot == 0) s = pal ? mk_span(972, 1035) : mk_span(795, 849);
            IVL_EQ: begin
                if (slot == 0) s = pal ? mk_span(972, 994) : mk_span(795, 815);
                else           s = pal ? mk_span(404, 426) : mk_span(340, 360);
            end
            IVL_VSYNC: begin
                if (slot == 0) s = pal ? mk_span(972, 302) : mk_span(795, 260);
                else           s = pal ? mk_span(404, 869) : mk_span(340, 715);
            end
            default: s = '0;
        endcase
        return s;
    endfunction

    function automatic logic [HCOUNT_W-1:0] line_len(input logic pal);
        return pal ? HCOUNT_W'(LINE_625) : HCOUNT_W'(LINE_525);
    endfunction

endpackage

// File: rtl/anc_window_decode.sv
module anc_window_decode
    import anc_pkg::*;
(
    input  logic                std_pal,
    input  ivl_e                ivl,
    input  logic [HCOUNT_W-1:0] hcount,
    output logic                in_win
);

    logic [NUM_SLOTS-1:0] slot_hit;
    logic                 in_line;

    assign in_line = (hcount < line_len(std_pal));

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        span_t sp;
        logic  wraps;
        always_comb begin
            sp    = span_lookup(std_pal, ivl, g);
            wraps = (sp.lo > sp.hi);
            if (!sp.en)
                slot_hit[g] = 1'b0;
            else if (wraps)
                slot_hit[g] = (hcount >= sp.lo) || (hcount <= sp.hi);
            else
                slot_hit[g] = (hcount >= sp.lo) && (hcount <= sp.hi);
        end
    end

    assign in_win = in_line && (|slot_hit);

endmodule

// File: rtl/anc_word_class.sv
module anc_word_class
    import anc_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              is_marker,
    output logic              is_reserved
);

    always_comb begin
        is_marker   = (word == MARKER_WORD);
        is_reserved = (word <= LOW_RSV_MAX) || (word > MARKER_WORD);
    end

endmodule

// File: rtl/anc_flag_watch.sv
module anc_flag_watch
    import anc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        std_pal,
    input  logic [1:0]  ivl_sel,
    input  logic [9:0]  word_i,
    input  logic [10:0] hcount_i,
    output logic        pkt_start_o,
    output logic        win_err_o,
    output logic        rsv_err_o
);

    mon_state_t st_d, st_q;
    logic       in_win;
    logic       is_marker;
    logic       is_reserved;
    ivl_e       ivl;

    assign ivl = ivl_e'(ivl_sel);

    anc_window_decode u_win (
        .std_pal (std_pal),
        .ivl     (ivl),
        .hcount  (hcount_i),
        .in_win  (in_win)
    );

    anc_word_class u_cls (
        .word        (word_i),
        .is_marker   (is_marker),
        .is_reserved (is_reserved)
    );

    always_comb begin
        st_d         = st_q;
        st_d.start   = is_marker && in_win;
        st_d.win_err = is_marker && !in_win;
        st_d.rsv_err = st_q.in_pkt && in_win && !is_marker && is_reserved;
        if (is_marker)
            st_d.in_pkt = in_win;
        else
            st_d.in_pkt = st_q.in_pkt && in_win;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pkt_start_o = st_q.start;
    assign win_err_o   = st_q.win_err;
    assign rsv_err_o   = st_q.rsv_err;

    p_start_after_marker_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start_o |-> ($past(word_i) == MARKER_WORD));

    p_werr_after_marker_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_err_o |-> ($past(word_i) == MARKER_WORD));

    p_rsv_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_err_o |-> ($past(word_i) <= 10'h003 || $past(word_i) >= 10'h3FD));

    p_rsv_needs_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_err_o |-> $past(in_win));

    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pkt_start_o, win_err_o}) <= 1);

    p_line_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_win |-> (hcount_i < (std_pal ? 11'd1135 : 11'd910)));

endmodule

// File: tb/anc_flag_watch_tb_top.sv
module anc_flag_watch_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        std_pal = 1'b0;
    logic [1:0]  ivl_sel = 2'd0;
    logic [9:0]  word_i = 10'd0;
    logic [10:0] hcount_i = 11'd0;
    logic        pkt_start_o, win_err_o, rsv_err_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;
    bit m_open  = 0;

    int edges[$] = '{795, 794, 849, 850, 815, 816, 340, 339, 360, 361, 260, 261,
                     715, 716, 972, 971, 1035, 1036, 994, 995, 404, 403, 426, 427,
                     302, 303, 869, 870, 0, 909, 1134};

    always #2.5 clk = ~clk;

    anc_flag_watch dut_i (
        .clk(clk), .rst_n(rst_n), .std_pal(std_pal), .ivl_sel(ivl_sel),
        .word_i(word_i), .hcount_i(hcount_i),
        .pkt_start_o(pkt_start_o), .win_err_o(win_err_o), .rsv_err_o(rsv_err_o));

    function automatic bit in_rng(int h, int lo, int hi, int len);
        if (h >= len) return 0;
        if (lo <= hi) return (h >= lo && h <= hi);
        return (h >= lo || h <= hi);
    endfunction

    // R3/R4 reference window table
    function automatic bit ref_win(bit pal, int ivl, int h);
        int len = pal ? 1135 : 910;
        case (ivl)
            0: return pal ? in_rng(h, 972, 1035, len) : in_rng(h, 795, 849, len);
            1: return pal ? (in_rng(h, 972, 994, len) || in_rng(h, 404, 426, len))
                          : (in_rng(h, 795, 815, len) || in_rng(h, 340, 360, len));
            2: return pal ? (in_rng(h, 972, 302, len) || in_rng(h, 404, 869, len))
                          : (in_rng(h, 795, 260, len) || in_rng(h, 340, 715, len));
            default: return 0;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (hcount %0d std %0d ivl %0d)",
                     req, act, exp, hcount_i, std_pal, ivl_sel);
        end
    endtask

    // drive one sample at a negedge, compare registered outputs one clock later (R9)
    task automatic step(int w, int h);
        bit mk, inw, rs, e_st, e_we, e_rs;
        word_i   = 10'(w);
        hcount_i = 11'(h);
        mk  = (w == 'h3FC);
        inw = ref_win(std_pal, ivl_sel, h);
        rs  = (w <= 3) || (w >= 'h3FD);
        e_st = mk && inw;                       // R2
        e_we = mk && !inw;                      // R5
        e_rs = m_open && inw && !mk && rs;      // R6, R8
        m_open = mk ? inw : (m_open && inw);
        @(negedge clk);
        chk("R2 pkt_start", pkt_start_o, e_st);
        chk("R5 win_err", win_err_o, e_we);
        chk("R6 rsv_err", rsv_err_o, e_rs);
    endtask

    function automatic int pat_word(int h, int pat);
        foreach (edges[i]) if (edges[i] == h) return 'h3FC;
        if (h % (pat ? 37 : 61) == 5) return 'h3FC;
        if (h % 5 == 2) begin
            case (h % 7)
                0: return 0; 1: return 1; 2: return 2; 3: return 3;
                4: return 'h3FD; 5: return 'h3FE; default: return 'h3FF;
            endcase
        end
        return 100 + (h % 600);
    endfunction

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                done = 1;
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
                $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        // R1 reset state
        word_i = 10'h3FC; hcount_i = 11'd800;
        repeat (3) @(negedge clk);
        chk("R1 reset pkt_start", pkt_start_o, 0);
        chk("R1 reset win_err", win_err_o, 0);
        chk("R1 reset rsv_err", rsv_err_o, 0);
        rst_n = 1'b1;
        word_i = 10'h001;
        @(negedge clk);
        chk("R1 after release rsv_err", rsv_err_o, 0);

        // R7 back-to-back markers, then reserved payload (R6)
        std_pal = 0; ivl_sel = 0;
        step('h3FC, 796);
        step('h3FC, 797);
        step('h3FE, 798);
        step('h000, 799);
        // R8 leave window then come back without marker
        step('h200, 850);
        step('h002, 820);
        // R4 count beyond line length
        ivl_sel = 2;
        step('h3FC, 950);
        step('h3FC, 1200);
        std_pal = 1;
        step('h3FC, 1136);
        step('h3FC, 1134);
        // R3 no-window setting
        ivl_sel = 3;
        step('h3FC, 1000);

        // full-line sweeps across every setting (R3, R4 wrap crossing, R6, R8)
        for (int pat = 0; pat < 2; pat++)
            for (int p = 0; p < 2; p++)
                for (int iv = 0; iv < 4; iv++) begin
                    std_pal = p[0];
                    ivl_sel = 2'(iv);
                    for (int ln = 0; ln < 2; ln++)
                        for (int h = 0; h < (p ? 1135 : 910); h++)
                            step(pat_word(h, pat), h);
                end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule